// File: doc/BRIEF.md
# Ethernet Flow-Control Pause Scheduler

This block decides when an Ethernet MAC transmitter has to insert flow-control traffic. Software sets a flow-control request bit, and a global enable must also be set for the request to count. In full-duplex operation the block then asks the transmit datapath to send a pause frame. The request carries the programmed pause time. After each such frame completes, a refresh counter counts bit-slot ticks. When the counter reaches the programmed refresh interval, the block asks for a further pause frame. When software withdraws the request, the block asks for one last pause frame with a pause time of zero so that the link partner resumes sending.

In half-duplex operation no pause frames are used. The block asserts a jam request instead, which tells the datapath to drive continuous preamble onto the medium. All requests begin only at a frame boundary, which the datapath reports as a busy flag. Any frame already in progress is therefore completed and never truncated. Pause requests use a request/acknowledge handshake, followed by a completion pulse. Building the frame contents and serialising them are left to the datapath.

Top module: `fc_pause_sched`

## Requirements
- R1: While `fc_enable` is 0, `pause_req` never rises, whatever `fc_request` and `half_duplex` hold.
- R2: With `half_duplex` = 0, `fc_enable` = 1 and `fc_request` = 1, `pause_req` rises only in a cycle after one where `tx_busy` was 0. A frame in progress therefore delays the request but does not cancel it.
- R3: `pause_time_o` takes the value of `pause_time` when the request is raised and keeps that value while the request is pending, even if `pause_time` changes later.
- R4: Once raised, `pause_req` stays high until `pause_ack` is seen and falls in the cycle after it. Only one request is outstanding at a time.
- R5: The refresh counter starts from zero when `pause_done` completes a non-zero pause frame. It advances once per `slot_tick` pulse. When its count is greater than or equal to `refresh_count`, a new pause request is raised. Lowering `refresh_count` below the current count therefore fires at once.
- R6: While the refresh counter runs, `tx_busy` frames proceed, and the refresh pause request waits until `tx_busy` is 0.
- R7: If `fc_request` falls after at least one non-zero pause frame has completed, a single request with `pause_time_o` = 0 is raised at the next frame boundary.
- R8: If `fc_request` falls before any pause frame has been requested, the pending request is cancelled and no pause request is raised.
- R9: With `half_duplex` = 1, `fc_enable` = 1 and `fc_request` = 1, `jam_req` is asserted and held for as long as the request stays set, and `pause_req` is never raised.
- R10: `jam_req` changes value only in a cycle after one where `tx_busy` was 0. Both assertion and release wait for the frame boundary.
- R11: Synchronous `rst` drops `pause_req` and `jam_req`, clears the refresh counter and returns the scheduler to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_enable | input | 1 | Global transmit flow-control enable |
| fc_request | input | 1 | Software flow-control request bit |
| half_duplex | input | 1 | 1 = half duplex (jam), 0 = full duplex (pause frames) |
| pause_time | input | PT_W | Programmed pause time for non-zero pause frames |
| refresh_count | input | RC_W | Slot ticks after a pause completes before a refresh pause |
| tx_busy | input | 1 | A data frame is in progress; 0 marks a frame boundary |
| slot_tick | input | 1 | One-cycle pulse per bit slot |
| pause_ack | input | 1 | Datapath accepts the pending pause request |
| pause_done | input | 1 | One-cycle pulse when the accepted pause frame has been sent |
| pause_req | output | 1 | Pause-frame request, held until acknowledged |
| pause_time_o | output | PT_W | Pause time to place in the requested frame |
| jam_req | output | 1 | Continuous-preamble jam request (half duplex) |

## Verification
The hardest conditions to reach from the ports are the refresh and zero-time paths, because each needs a complete pause exchange first. For a refresh or a zero-time pause, the bench must raise a request, acknowledge it and pulse completion, then count slot ticks. For the lowered-limit case, the bench also rewrites `refresh_count` below the count already reached. Each directed task starts from reset and performs that exchange itself. It then holds `tx_busy` high across the moment the refresh count is reached, which shows that the refresh request waits for the boundary. The cancellation case holds `tx_busy` high so that the request can be withdrawn while it is still pending.

// File: rtl/fc_pause_pkg.sv
package fc_pause_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PEND  = 3'd1,
      ST_REQ   = 3'd2,
      ST_SEND  = 3'd3,
      ST_COUNT = 3'd4,
      ST_ZPEND = 3'd5
   } fc_state_e;
endpackage

// File: rtl/fc_mirror_cnt.sv
module fc_mirror_cnt #(
   parameter int RC_W     = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clr,
   input  logic            run,
   input  logic            tick,
   input  logic [RC_W-1:0] limit,
   output logic            reached
);
   localparam logic [RC_W-1:0] CNT_MAX = {RC_W{1'b1}};

   logic [RC_W-1:0] cnt_q;
   logic [RC_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (run && tick) cnt_q <= cnt_inc;
   end

   assign reached = run && (cnt_q >= limit);

   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !tick) |=> $stable(cnt_q));

   // R5
   cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/fc_pause_fsm.sv
module fc_pause_fsm
   import fc_pause_pkg::*;
#(
   parameter int PT_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fc_enable,
   input  logic            fc_request,
   input  logic            half_duplex,
   input  logic [PT_W-1:0] pause_time,
   input  logic            tx_busy,
   input  logic            pause_ack,
   input  logic            pause_done,
   input  logic            refresh_hit,
   output logic            pause_req,
   output logic [PT_W-1:0] pause_time_o,
   output logic            cnt_clr,
   output logic            cnt_run
);
   fc_state_e       st_q, st_d;
   logic            sent_q;
   logic            zero_q;
   logic [PT_W-1:0] time_q;
   logic            active;
   logic            zero_ok;

   assign active  = fc_enable && fc_request && !half_duplex;
   assign zero_ok = fc_enable && !half_duplex;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (active) st_d = ST_PEND;
         ST_PEND: begin
            if (!active) st_d = (zero_ok && sent_q) ? ST_ZPEND : ST_IDLE;
            else if (!tx_busy) st_d = ST_REQ;
         end
         ST_REQ:   if (pause_ack) st_d = ST_SEND;
         ST_SEND:  if (pause_done) st_d = zero_q ? ST_IDLE : ST_COUNT;
         ST_COUNT: begin
            if (!active) st_d = zero_ok ? ST_ZPEND : ST_IDLE;
            else if (refresh_hit) st_d = ST_PEND;
         end
         ST_ZPEND: begin
            if (!zero_ok) st_d = ST_IDLE;
            else if (!tx_busy) st_d = ST_REQ;
         end
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         sent_q <= 1'b0;
         zero_q <= 1'b0;
         time_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d == ST_IDLE) sent_q <= 1'b0;
         else if (st_q == ST_SEND && pause_done && !zero_q) sent_q <= 1'b1;
         if (st_d == ST_REQ && st_q != ST_REQ) begin
            zero_q <= (st_q == ST_ZPEND);
            time_q <= (st_q == ST_ZPEND) ? '0 : pause_time;
         end
      end
   end

   assign pause_req    = (st_q == ST_REQ);
   assign pause_time_o = time_q;
   assign cnt_run      = (st_q == ST_COUNT);
   assign cnt_clr      = (st_q != ST_COUNT);

   // R1
   req_enable_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pause_req) |-> $past(fc_enable));

   // R2
   req_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pause_req) |-> !$past(tx_busy));

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pause_req && !pause_ack) |=> (pause_req && $stable(pause_time_o)));

   // R4
   req_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (pause_req && pause_ack) |=> !pause_req);
endmodule

// File: rtl/fc_jam_ctrl.sv
module fc_jam_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic fc_enable,
   input  logic fc_request,
   input  logic half_duplex,
   input  logic tx_busy,
   output logic jam_req
);
   logic want;
   logic jam_q;

   assign want = fc_enable && fc_request && half_duplex;

   always_ff @(posedge clk) begin
      if (rst) jam_q <= 1'b0;
      else if (!tx_busy) jam_q <= want;
   end

   assign jam_req = jam_q;

   // R10
   jam_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(jam_req) |-> !$past(tx_busy));
endmodule

// File: rtl/fc_pause_sched.sv
module fc_pause_sched #(
   parameter int PT_W         = 16,
   parameter int RC_W         = 16,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fc_enable,
   input  logic            fc_request,
   input  logic            half_duplex,
   input  logic [PT_W-1:0] pause_time,
   input  logic [RC_W-1:0] refresh_count,
   input  logic            tx_busy,
   input  logic            slot_tick,
   input  logic            pause_ack,
   input  logic            pause_done,
   output logic            pause_req,
   output logic [PT_W-1:0] pause_time_o,
   output logic            jam_req
);
   generate
      if (PT_W < 1 || PT_W > 32) begin : g_bad_pt
         $error("PT_W out of range");
      end
      if (RC_W < 1 || RC_W > 32) begin : g_bad_rc
         $error("RC_W out of range");
      end
   endgenerate

   logic cnt_clr;
   logic cnt_run;
   logic refresh_hit;

   fc_pause_fsm #(.PT_W(PT_W)) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .fc_enable    (fc_enable),
      .fc_request   (fc_request),
      .half_duplex  (half_duplex),
      .pause_time   (pause_time),
      .tx_busy      (tx_busy),
      .pause_ack    (pause_ack),
      .pause_done   (pause_done),
      .refresh_hit  (refresh_hit),
      .pause_req    (pause_req),
      .pause_time_o (pause_time_o),
      .cnt_clr      (cnt_clr),
      .cnt_run      (cnt_run)
   );

   fc_mirror_cnt #(.RC_W(RC_W), .SATURATE(CNT_SATURATE)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (cnt_clr),
      .run     (cnt_run),
      .tick    (slot_tick),
      .limit   (refresh_count),
      .reached (refresh_hit)
   );

   fc_jam_ctrl u_jam (
      .clk         (clk),
      .rst         (rst),
      .fc_enable   (fc_enable),
      .fc_request  (fc_request),
      .half_duplex (half_duplex),
      .tx_busy     (tx_busy),
      .jam_req     (jam_req)
   );

   // R9
   no_pause_half_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pause_req) |-> !$past(half_duplex));

   // R11
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!pause_req && !jam_req));
endmodule

// File: tb/fc_pause_sched_tb.sv
`timescale 1ns/1ps
module fc_pause_sched_tb;
   localparam int PT_W = 16;
   localparam int RC_W = 16;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            fc_enable = 1'b0, fc_request = 1'b0, half_duplex = 1'b0;
   logic [PT_W-1:0] pause_time = '0;
   logic [RC_W-1:0] refresh_count = '0;
   logic            tx_busy = 1'b0, slot_tick = 1'b0;
   logic            pause_ack = 1'b0, pause_done = 1'b0;
   logic            pause_req, jam_req;
   logic [PT_W-1:0] pause_time_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   fc_pause_sched #(.PT_W(PT_W), .RC_W(RC_W)) u_dut (
      .clk(clk), .rst(rst), .fc_enable(fc_enable), .fc_request(fc_request),
      .half_duplex(half_duplex), .pause_time(pause_time),
      .refresh_count(refresh_count), .tx_busy(tx_busy), .slot_tick(slot_tick),
      .pause_ack(pause_ack), .pause_done(pause_done), .pause_req(pause_req),
      .pause_time_o(pause_time_o), .jam_req(jam_req)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; fc_enable = 1'b0; fc_request = 1'b0; half_duplex = 1'b0;
      tx_busy = 1'b0; slot_tick = 1'b0; pause_ack = 1'b0; pause_done = 1'b0;
      pause_time = 16'h1234; refresh_count = 16'd4;
      cyc(2);
      rst = 1'b0;
      cyc(1);
   endtask

   task automatic wait_req(input int max, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < max && !seen; i++) begin
         @(negedge clk);
         if (pause_req) seen = 1'b1;
      end
   endtask

   task automatic no_req(input int n, output bit quiet);
      quiet = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pause_req) quiet = 1'b0;
      end
   endtask

   task automatic finish_pause();
      pause_ack = 1'b1; cyc(1); pause_ack = 1'b0; cyc(2);
      pause_done = 1'b1; cyc(1); pause_done = 1'b0; cyc(2);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         slot_tick = 1'b1; cyc(1); slot_tick = 1'b0; cyc(1);
      end
   endtask

   task automatic t_reset();
      bit q;
      do_reset();
      chk(!pause_req && !jam_req, "R11 reset outputs", {pause_req, jam_req}, 0);
      fc_request = 1'b1; half_duplex = 1'b0;
      no_req(30, q);
      chk(q, "R1 disabled no pause", 1, 0);
   endtask

   task automatic t_defer();
      bit s, q;
      do_reset();
      fc_enable = 1'b1; tx_busy = 1'b1; fc_request = 1'b1;
      no_req(20, q);
      chk(q, "R2 no pause while busy", 0, 0);
      tx_busy = 1'b0;
      wait_req(4, s);
      chk(s, "R2 pause after boundary", s, 1);
      chk(pause_time_o == 16'h1234, "R3 pause time", pause_time_o, 16'h1234);
      pause_time = 16'h0BEE;
      cyc(8);
      chk(pause_req, "R4 held until ack", pause_req, 1);
      chk(pause_time_o == 16'h1234, "R3 time latched", pause_time_o, 16'h1234);
      pause_ack = 1'b1; cyc(1); pause_ack = 1'b0;
      chk(!pause_req, "R4 drop after ack", pause_req, 0);
   endtask

   task automatic t_refresh();
      bit s, q;
      do_reset();
      fc_enable = 1'b1; fc_request = 1'b1;
      wait_req(4, s);
      finish_pause();
      ticks(3);
      no_req(5, q);
      chk(q, "R5 no refresh before limit", 0, 0);
      ticks(1);
      wait_req(4, s);
      chk(s, "R5 refresh at limit", s, 1);
      chk(pause_time_o == 16'h1234, "R5 refresh time", pause_time_o, 16'h1234);
      finish_pause();
      tx_busy = 1'b1;
      ticks(5);
      no_req(5, q);
      chk(q, "R6 refresh waits for boundary", 0, 0);
      tx_busy = 1'b0;
      wait_req(4, s);
      chk(s, "R6 refresh after boundary", s, 1);
   endtask

   task automatic t_lower();
      bit s, q;
      do_reset();
      refresh_count = 16'd100;
      fc_enable = 1'b1; fc_request = 1'b1;
      wait_req(4, s);
      finish_pause();
      ticks(5);
      no_req(3, q);
      chk(q, "R5 no early refresh", 0, 0);
      refresh_count = 16'd3;
      wait_req(4, s);
      chk(s, "R5 lowered limit fires", s, 1);
   endtask

   task automatic t_zero();
      bit s, q;
      do_reset();
      fc_enable = 1'b1; fc_request = 1'b1;
      wait_req(4, s);
      finish_pause();
      fc_request = 1'b0;
      wait_req(4, s);
      chk(s, "R7 zero pause raised", s, 1);
      chk(pause_time_o == 16'h0, "R7 zero pause time", pause_time_o, 0);
      finish_pause();
      no_req(20, q);
      chk(q, "R7 single zero pause", 0, 0);
   endtask

   task automatic t_cancel();
      bit q;
      do_reset();
      fc_enable = 1'b1; tx_busy = 1'b1; fc_request = 1'b1;
      cyc(5);
      fc_request = 1'b0;
      cyc(2);
      tx_busy = 1'b0;
      no_req(30, q);
      chk(q, "R8 cancelled request", 0, 0);
   endtask

   task automatic t_half();
      bit q;
      do_reset();
      half_duplex = 1'b1; fc_enable = 1'b1; tx_busy = 1'b1; fc_request = 1'b1;
      cyc(10);
      chk(!jam_req, "R10 jam waits for boundary", jam_req, 0);
      tx_busy = 1'b0;
      cyc(2);
      chk(jam_req, "R9 jam asserted", jam_req, 1);
      no_req(20, q);
      chk(q && jam_req, "R9 jam held, no pause", {q, jam_req}, 3);
      tx_busy = 1'b1; fc_request = 1'b0;
      cyc(6);
      chk(jam_req, "R10 release waits for boundary", jam_req, 1);
      tx_busy = 1'b0;
      cyc(2);
      chk(!jam_req, "R9 jam released", jam_req, 0);
      fc_request = 1'b1;
      cyc(2);
      rst = 1'b1; cyc(1);
      chk(!jam_req && !pause_req, "R11 reset drops jam", jam_req, 0);
      rst = 1'b0;
   endtask

   initial begin
      t_reset();
      t_defer();
      t_refresh();
      t_lower();
      t_zero();
      t_cancel();
      t_half();
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule